// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a two-port host interface to an embedded controller. The host sees a data port at offset 0 and a shared port at offset 4. Reading offset 4 gives a status byte. Writing it delivers a command byte. Every byte the host writes raises an input-buffer-full flag. The flag falls once an internal sequencer has taken the byte, which happens a fixed, parameterised number of clock cycles later. A byte the controller hands back raises an output-buffer-full flag, and the host clears that flag by reading the data port.

The command bytes drive short sequences. A read command followed by an address byte produces one read on the back-side register bus, and the value read is placed in the data port. A write command followed by an address byte and a data byte produces one register write. Two further commands set and clear a burst flag, which is shown in the status byte. A query command returns a zero event code. The back-side bus is a simple synchronous strobe with an asynchronous read path. It reaches a 256-entry register file that lives outside this block.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00. No register access is issued, and the data port reads 0x00.
- R2: A host write to offset 4 (command) or offset 0 (data) sets IBF (status bit 1) from the next cycle on. Status bit 3 reads 1 after a command write and 0 after a data write.
- R3: IBF clears exactly CONSUME_CYC clock edges after the edge that took the write. A further host write before then replaces the held byte and restarts that count.
- R4: Command 0x80 followed by an address byte issues exactly one register read of that address. The value read is then loaded into the data port, and OBF (status bit 0) is set.
- R5: Command 0x81 followed by an address byte and a data byte issues exactly one register write of that data to that address. OBF stays clear.
- R6: A host read of the data port returns the held byte, and OBF reads 0 afterwards.
- R7: Command 0x82 sets the burst flag (status bit 4). Command 0x83 clears it.
- R8: Command 0x84 loads 0x00 into the data port and sets OBF.
- R9: A command byte that arrives part-way through a sequence discards that sequence. Decoding then starts again from the new command.
- R10: An unknown command code, or a data byte with no sequence open, is consumed with no effect. IBF clears, no register access occurs, and OBF and the burst flag keep their values.
- R11: Host accesses at offsets other than 0 and 4 are ignored. Writes there do not set IBF, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe, one cycle per byte |
| hst_rd | input | 1 | Host read strobe, one cycle per byte |
| hst_addr | input | 3 | Host port offset (0 data, 4 status/command) |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, valid in the cycle hst_rd is high |
| reg_req | output | 1 | Register bus strobe, one cycle |
| reg_we | output | 1 | Register bus direction, 1 for write |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Register write byte |
| reg_rdata | input | 8 | Register read byte, combinational from reg_addr |

## Verification
The sequencer is driven with complete read and write sequences. These show that the address byte and the data byte are routed to the right back-side fields. A write followed by a read-back of the same address shows that the two paths agree. Interrupted sequences and unknown codes separate a decoder that restarts on every command byte from one that keeps a stale state. Stray data bytes and accesses at unused offsets show that nothing leaks into the register bus or the flags. IBF is also polled cycle by cycle after single and back-to-back writes, to pin the consume delay and its restart.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_REG_READ  = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_REG_WRITE = 8'h81;
  localparam logic [BYTE_W-1:0] CMD_BURST_ON  = 8'h82;
  localparam logic [BYTE_W-1:0] CMD_BURST_OFF = 8'h83;
  localparam logic [BYTE_W-1:0] CMD_QUERY     = 8'h84;

  localparam int ST_OBF   = 0;
  localparam int ST_IBF   = 1;
  localparam int ST_CMD   = 3;
  localparam int ST_BURST = 4;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RD_ADDR,
    SQ_WR_ADDR,
    SQ_WR_DATA
  } seq_st_t;

  function automatic logic [BYTE_W-1:0] pack_status(input logic obf, input logic ibf,
                                                    input logic cmd, input logic burst);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_OBF]   = obf;
    s[ST_IBF]   = ibf;
    s[ST_CMD]   = cmd;
    s[ST_BURST] = burst;
    return s;
  endfunction

  function automatic logic is_known_cmd(input logic [BYTE_W-1:0] c);
    return (c >= CMD_REG_READ) && (c <= CMD_QUERY);
  endfunction

endpackage

// File: rtl/ec_ibf_timer.sv
module ec_ibf_timer #(
  parameter int CONSUME_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic consume
);
  localparam int CNT_W = $clog2(CONSUME_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= CNT_W'(CONSUME_CYC);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  // a reload in the same cycle wins: the replaced byte is never consumed
  assign consume = (cnt_q == CNT_W'(1)) && !load;

  a_r3_count_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == CNT_W'(CONSUME_CYC)));

endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq
  import ec_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              consume,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_is_cmd,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              out_vld,
  output logic [BYTE_W-1:0] out_byte,
  output logic              burst
);
  seq_st_t st_q;
  logic    rd_land;
  logic    cmd_unknown;

  assign rd_land     = reg_req && !reg_we;
  assign cmd_unknown = consume && in_is_cmd && !is_known_cmd(in_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      out_vld   <= 1'b0;
      out_byte  <= '0;
      burst     <= 1'b0;
    end else begin
      reg_req <= 1'b0;
      out_vld <= 1'b0;
      if (rd_land) begin
        out_vld  <= 1'b1;
        out_byte <= reg_rdata;
      end
      if (consume) begin
        if (in_is_cmd) begin
          st_q <= SQ_IDLE;
          case (in_byte)
            CMD_REG_READ:  st_q  <= SQ_RD_ADDR;
            CMD_REG_WRITE: st_q  <= SQ_WR_ADDR;
            CMD_BURST_ON:  burst <= 1'b1;
            CMD_BURST_OFF: burst <= 1'b0;
            CMD_QUERY: begin
              out_vld  <= 1'b1;
              out_byte <= '0;
            end
            default: ;
          endcase
        end else begin
          case (st_q)
            SQ_RD_ADDR: begin
              reg_req  <= 1'b1;
              reg_we   <= 1'b0;
              reg_addr <= in_byte;
              st_q     <= SQ_IDLE;
            end
            SQ_WR_ADDR: begin
              reg_addr <= in_byte;
              st_q     <= SQ_WR_DATA;
            end
            SQ_WR_DATA: begin
              reg_req   <= 1'b1;
              reg_we    <= 1'b1;
              reg_wdata <= in_byte;
              st_q      <= SQ_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  a_r5_write_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we) |-> ($past(st_q) == SQ_WR_DATA));

  a_r10_unknown_idles: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_unknown |=> (st_q == SQ_IDLE) && !reg_req && (burst == $past(burst)));

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_host_pkg::*;
#(
  parameter int CONSUME_CYC = 4,
  parameter int HADDR_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_wr,
  input  logic               hst_rd,
  input  logic [HADDR_W-1:0] hst_addr,
  input  logic [7:0]         hst_wdata,
  output logic [7:0]         hst_rdata,
  output logic               reg_req,
  output logic               reg_we,
  output logic [7:0]         reg_addr,
  output logic [7:0]         reg_wdata,
  input  logic [7:0]         reg_rdata
);
  localparam logic [HADDR_W-1:0] OFS_DATA = HADDR_W'(0);
  localparam logic [HADDR_W-1:0] OFS_CTRL = HADDR_W'(4);

  logic              sel_data, sel_ctrl;
  logic              host_wr_any, host_wr_cmd, host_rd_data;
  logic              consume, out_vld, burst;
  logic [BYTE_W-1:0] out_byte;
  logic [BYTE_W-1:0] in_byte_q;
  logic              in_is_cmd_q, ibf_q, obf_q;

  assign sel_data     = (hst_addr == OFS_DATA);
  assign sel_ctrl     = (hst_addr == OFS_CTRL);
  assign host_wr_any  = hst_wr && (sel_data || sel_ctrl);
  assign host_wr_cmd  = hst_wr && sel_ctrl;
  assign host_rd_data = hst_rd && sel_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_byte_q   <= '0;
      in_is_cmd_q <= 1'b0;
      ibf_q       <= 1'b0;
    end else if (host_wr_any) begin
      in_byte_q   <= hst_wdata;
      in_is_cmd_q <= host_wr_cmd;
      ibf_q       <= 1'b1;
    end else if (consume) begin
      ibf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            obf_q <= 1'b0;
    else if (out_vld)      obf_q <= 1'b1;
    else if (host_rd_data) obf_q <= 1'b0;
  end

  always_comb begin
    hst_rdata = '0;
    if (sel_data)      hst_rdata = out_byte;
    else if (sel_ctrl) hst_rdata = pack_status(obf_q, ibf_q, in_is_cmd_q, burst);
  end

  ec_ibf_timer #(.CONSUME_CYC(CONSUME_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (host_wr_any),
    .consume (consume)
  );

  ec_cmd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .consume   (consume),
    .in_byte   (in_byte_q),
    .in_is_cmd (in_is_cmd_q),
    .reg_rdata (reg_rdata),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .out_vld   (out_vld),
    .out_byte  (out_byte),
    .burst     (burst)
  );

  a_r2_cmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_cmd |=> ibf_q && in_is_cmd_q);

  a_r3_consume_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> ibf_q);

  a_r4_obf_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> obf_q);

  a_r6_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_data && !out_vld) |=> !obf_q);

  a_r11_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && !sel_data && !sel_ctrl && !ibf_q) |=> !ibf_q);

endmodule

// File: tb/ec_host_port_bench.sv
module ec_host_port_bench;
  localparam int CYC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_wr = 1'b0, hst_rd = 1'b0;
  logic [2:0] hst_addr = '0;
  logic [7:0] hst_wdata = '0, hst_rdata;
  logic       reg_req, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  logic [7:0] mem [256];
  int n_wr = 0, n_rd = 0;
  logic [7:0] last_wa, last_wd, last_ra;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (rst_n && reg_req) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata; n_wr <= n_wr + 1;
      last_wa <= reg_addr; last_wd <= reg_wdata;
    end else begin
      n_rd <= n_rd + 1; last_ra <= reg_addr;
    end
  end

  ec_host_port #(.CONSUME_CYC(CYC)) u_ec_host_port (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // all tasks start and end at a falling edge
  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    hst_rd = 1'b1; hst_addr = a;
    #1 d = hst_rdata;
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ibf_clear();
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      host_rd(3'd4, s);
      if (!s[1]) return;
    end
    chk("R3 ibf stuck", 1, 0);
  endtask

  task automatic wait_obf_set();
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      host_rd(3'd4, s);
      if (s[0]) return;
    end
    chk("R4 obf never set", 0, 1);
  endtask

  task automatic put(input logic [2:0] a, input logic [7:0] d);
    host_wr(a, d);
    wait_ibf_clear();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    host_rd(3'd4, v); chk("R1 status", v, 8'h00);
    host_rd(3'd0, v); chk("R1 data", v, 8'h00);
    chk("R1 no reg access", n_wr + n_rd, 0);
  endtask

  task automatic t_ibf_timing();
    logic [7:0] s;
    int first;
    host_wr(3'd0, 8'h11);
    first = -1;
    for (int i = 0; i < 3 * CYC; i++) begin
      host_rd(3'd4, s);
      if (i == 0) chk("R2 ibf set, data flag", s & 8'h0A, 8'h02);
      if (first < 0 && !s[1]) first = i;
    end
    chk("R3 ibf clear cycle", first, CYC);
    host_wr(3'd4, 8'hEE);
    host_rd(3'd4, s); chk("R2 cmd flag", s & 8'h0A, 8'h0A);
    idle(CYC - 3);
    host_wr(3'd4, 8'hEF);
    first = -1;
    for (int i = 0; i < 3 * CYC; i++) begin
      host_rd(3'd4, s);
      if (first < 0 && !s[1]) first = i;
    end
    chk("R3 restart on rewrite", first, CYC);
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
    put(3'd4, 8'h80);
    put(3'd0, a);
    wait_obf_set();
    host_rd(3'd0, v);
  endtask

  task automatic t_read();
    logic [7:0] v, s;
    int r0;
    r0 = n_rd;
    read_reg(8'h3C, v);
    chk("R4 read value", v, 8'hA5);
    chk("R4 one read", n_rd - r0, 1);
    chk("R4 read addr", last_ra, 8'h3C);
    host_rd(3'd4, s); chk("R6 obf cleared", s[0], 0);
  endtask

  task automatic t_write();
    logic [7:0] v, s;
    int w0;
    w0 = n_wr;
    put(3'd4, 8'h81); put(3'd0, 8'h44); put(3'd0, 8'h9E);
    idle(2);
    chk("R5 one write", n_wr - w0, 1);
    chk("R5 write addr", last_wa, 8'h44);
    chk("R5 write data", last_wd, 8'h9E);
    host_rd(3'd4, s); chk("R5 no obf", s, 8'h00);
    read_reg(8'h44, v); chk("R5 read back", v, 8'h9E);
  endtask

  task automatic t_burst();
    logic [7:0] s;
    put(3'd4, 8'h82); host_rd(3'd4, s); chk("R7 burst on", s, 8'h18);
    put(3'd4, 8'h83); host_rd(3'd4, s); chk("R7 burst off", s, 8'h08);
  endtask

  task automatic t_query();
    logic [7:0] v, s;
    mem[8'h3C] = 8'hA5;
    read_reg(8'h3C, v);
    put(3'd4, 8'h84);
    wait_obf_set();
    host_rd(3'd0, v); chk("R8 query code", v, 8'h00);
    host_rd(3'd4, s); chk("R6 obf after query read", s[0], 0);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    int w0, r0;
    w0 = n_wr; r0 = n_rd;
    put(3'd4, 8'h81); put(3'd0, 8'h10);
    read_reg(8'h20, v);
    chk("R9 no write", n_wr - w0, 0);
    chk("R9 read addr", last_ra, 8'h20);
    chk("R9 read value", v, 8'h5A);
    chk("R9 one read", n_rd - r0, 1);
  endtask

  task automatic t_unknown();
    logic [7:0] s, v;
    int c0;
    put(3'd4, 8'h82);
    put(3'd4, 8'h84);
    wait_obf_set();
    c0 = n_wr + n_rd;
    put(3'd4, 8'hA7); idle(3);
    host_rd(3'd4, s); chk("R10 unknown cmd status", s, 8'h19);
    put(3'd4, 8'h81); put(3'd4, 8'h00); put(3'd0, 8'h33); put(3'd0, 8'h66); idle(3);
    host_rd(3'd4, s); chk("R10 stray data status", s, 8'h11);
    chk("R10 no reg access", n_wr + n_rd - c0, 0);
    host_rd(3'd0, v); chk("R10 data port kept", v, 8'h00);
    put(3'd4, 8'h83);
  endtask

  task automatic t_offset();
    logic [7:0] s, v;
    int c0;
    c0 = n_wr + n_rd;
    host_wr(3'd2, 8'h81); host_wr(3'd6, 8'h80);
    host_rd(3'd4, s); chk("R11 no ibf", s[1], 0);
    host_rd(3'd2, v); chk("R11 read stray", v, 8'h00);
    idle(CYC + 2);
    chk("R11 no reg access", n_wr + n_rd - c0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    mem[8'h3C] = 8'hA5; mem[8'h20] = 8'h5A;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ibf_timing();
    t_read();
    t_write();
    t_burst();
    t_query();
    t_abort();
    t_unknown();
    t_offset();
    finish_run();
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

endmodule